// File: doc/BRIEF.md
# Multiplexed bus cycle sequencer

This block is the external bus state machine of a small 16-bit controller whose data leaves the chip over an 8-bit bus shared between address and data. The core hands it one request at a time. A request carries a cycle kind, a 20-bit address, write data, and two chip-select region flags. The block then runs the cycle on the pins. It drives the address latch strobe, the active-low read and write strobes, a 3-bit status code, a separate address bus, and the shared address/data lines. When the addressed device is slow, it stretches the cycle with wait states.

The cycle uses six named states:
- `ST_TI`: idle.
- `ST_T1`: address phase.
- `ST_T2`: strobe start.
- `ST_T3`: first ready sample.
- `ST_TW`: wait.
- `ST_T4`: cycle end, with read data presented.

The transitions are:
- TI→T1 when a request is taken.
- T1→T2 and T2→T3 always.
- T3→T4 or TW→T4 when ready is seen.
- T3→TW or TW→TW while it is not.
- T4→T1 when another request is already waiting.
- T4→TI otherwise.

Two ready inputs control the wait states. The synchronous one is used as it arrives. The asynchronous one has its rising edge passed through a two-stage synchronizer, while its falling edge takes effect at once. A strap sampled during reset, together with a per-request region flag and disable bit, can keep the address off the shared lines for cycles to selected chip-select regions.

Top module: `mbus_seq`

## Requirements
- R1: While reset is active and right after it is released, rd_n and wr_n are 1, addr_latch is 0, bus_stat is 3'b111, ad_oe is 0 and req_ready is 1.
- R2: bus_stat shows the request kind during T1, T2, T3 and every Tw, and shows 3'b111 (passive) in T4 and in idle. The kind codes are: 3'b000 interrupt acknowledge, 3'b001 I/O read, 3'b010 I/O write, 3'b011 halt, 3'b100 fetch, 3'b101 memory read, 3'b110 memory write. Bit 2 separates memory from I/O, and bit 1 is high for writes.
- R3: addr_latch is high for exactly the one T1 clock. abus carries the request address from the start of T1 through T4.
- R4: The shared bus ad_out drives the low address byte from the falling clock edge inside T1. This is half a clock after abus changes, and the byte is valid when addr_latch falls.
- R5: rd_n is low in T2, T3 and every Tw of memory reads, I/O reads and fetches, and is high in all other cycles. During such a read, ad_oe is 0 from the falling edge inside T2.
- R6: wr_n is low in T2, T3 and every Tw of memory and I/O writes. ad_out carries the write byte with ad_oe=1 from the falling edge inside T2 to the falling edge inside T4.
- R7: Ready is sampled at the end of T3 and at the end of each Tw. The effective ready is rdy_sync OR the filtered rdy_async. The count of Tw states equals the number of such samples that saw no ready. With both inputs held high, no Tw is inserted.
- R8: A rising edge on rdy_async counts only once it has been seen at two successive clock edges, so it acts two clocks after it is raised. A low level on rdy_async stops it from counting at once. With rdy_async held low, rdy_sync alone decides.
- R9: addr_dis_strap is captured on the clock edges while reset is active. With the strap set, req_cs_hit=1 and req_da=1, ad_oe stays 0 through the T1 address phase. In every other combination, the address is driven.
- R10: For reads, fetches and interrupt acknowledge, the ad_in byte seen at the ready edge appears on rdata while cyc_done is high in T4.
- R11: req_ready is high in idle and in T4. A request held at the end of T4 starts T1 on the next clock with no idle state between the two cycles.
- R12: Halt and interrupt acknowledge cycles run T1 through T4 with rd_n and wr_n both staying high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_dis_strap | input | 1 | Address-suppression option, captured while in reset |
| req_valid | input | 1 | A request is offered |
| req_kind | input | 3 | Cycle kind, using the status code (3'b111 not allowed) |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write byte |
| req_cs_hit | input | 1 | Address lies in the lower or upper chip-select region |
| req_da | input | 1 | Address-disable control bit of that region |
| req_ready | output | 1 | Request is taken at this clock edge when req_valid is high |
| rdy_async | input | 1 | Asynchronous ready |
| rdy_sync | input | 1 | Synchronous ready |
| addr_latch | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_stat | output | 3 | Bus status code |
| abus | output | ADDR_W | Non-multiplexed address bus |
| ad_out | output | DATA_W | Shared address/data bus, outgoing value |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | DATA_W | Shared address/data bus, incoming value |
| cyc_done | output | 1 | High during T4 |
| rdata | output | DATA_W | Captured read byte, valid with cyc_done |

## Verification
The checker assumes three things about the inputs:
- Kind code 3'b111 is never requested.
- rdy_sync changes only away from the clock edge.
- rdy_async falls only away from the clock edge.

Under these assumptions, a strobe held with both ready inputs low must still be active on the next clock. The bench drives every ready and request input a fraction of a clock after the rising edge, so each level is settled well before the next edge. It lowers rdy_async at the start of T1, before the first possible sample, and then raises it at a planned cycle so that the number of wait states is known in advance.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        CYC_INTA  = 3'b000,
        CYC_IORD  = 3'b001,
        CYC_IOWR  = 3'b010,
        CYC_HALT  = 3'b011,
        CYC_FETCH = 3'b100,
        CYC_MEMRD = 3'b101,
        CYC_MEMWR = 3'b110,
        CYC_IDLE  = 3'b111
    } cyc_e;

    typedef enum logic [2:0] {
        ST_TI,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4
    } bus_st_e;

    function automatic logic strobes_rd(cyc_e k);
        return (k == CYC_IORD) || (k == CYC_FETCH) || (k == CYC_MEMRD);
    endfunction

    function automatic logic strobes_wr(cyc_e k);
        return (k == CYC_IOWR) || (k == CYC_MEMWR);
    endfunction

    function automatic logic grabs_data(cyc_e k);
        return strobes_rd(k) || (k == CYC_INTA);
    endfunction

endpackage

// File: rtl/mbus_rdy.sv
module mbus_rdy #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_async,
    input  logic rdy_sync,
    output logic rdy_eff
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] chain_q;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[TOP-1:0], rdy_async};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= rdy_async;
            end
        end
    endgenerate

    // rising edge waits for the chain, falling edge cuts through the live level
    assign rdy_eff = rdy_sync | (rdy_async & chain_q[TOP]);

endmodule

// File: rtl/mbus_fsm.sv
module mbus_fsm
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  cyc_e              req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_supp,
    input  logic              rdy,
    input  logic [DATA_W-1:0] ad_in,
    output logic              req_ready,
    output bus_st_e           state,
    output cyc_e              kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              supp_q,
    output logic              addr_latch,
    output logic              rd_n,
    output logic              wr_n,
    output cyc_e              bus_stat,
    output logic              cyc_done,
    output logic [DATA_W-1:0] rdata
);
    bus_st_e nxt;
    logic    take;
    logic    sample_pt;

    assign req_ready = (state == ST_TI) || (state == ST_T4);
    assign take      = req_valid && req_ready;
    assign sample_pt = (state == ST_T3) || (state == ST_TW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_TI;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_TI:   nxt = req_valid ? ST_T1 : ST_TI;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = rdy ? ST_T4 : ST_TW;
            ST_TW:   nxt = rdy ? ST_T4 : ST_TW;
            ST_T4:   nxt = req_valid ? ST_T1 : ST_TI;
            default: nxt = ST_TI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= CYC_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            supp_q  <= 1'b0;
            rdata   <= '0;
        end else begin
            if (take) begin
                kind_q  <= req_kind;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                supp_q  <= req_supp;
            end
            if (sample_pt && rdy && grabs_data(kind_q)) begin
                rdata <= ad_in;
            end
        end
    end

    always_comb begin
        addr_latch = 1'b0;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        bus_stat   = CYC_IDLE;
        cyc_done   = 1'b0;
        unique case (state)
            ST_TI: ;
            ST_T1: begin
                addr_latch = 1'b1;
                bus_stat   = kind_q;
            end
            ST_T2, ST_T3, ST_TW: begin
                bus_stat = kind_q;
                rd_n     = !strobes_rd(kind_q);
                wr_n     = !strobes_wr(kind_q);
            end
            ST_T4:   cyc_done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mbus_addr_drv.sv
module mbus_addr_drv
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap,
    input  bus_st_e           state,
    input  cyc_e              kind_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              supp_q,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);
    logic strap_q;

    // strap is captured on every edge seen while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap;
    end

    // launched on the falling edge: half a clock behind abus
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ad_out <= '0;
            ad_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_T1: begin
                    ad_out <= addr_q[DATA_W-1:0];
                    ad_oe  <= !(strap_q && supp_q);
                end
                ST_T2, ST_T3, ST_TW: begin
                    ad_out <= wdata_q;
                    ad_oe  <= strobes_wr(kind_q);
                end
                default: ad_oe <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_dis_strap,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_cs_hit,
    input  logic              req_da,
    output logic              req_ready,
    input  logic              rdy_async,
    input  logic              rdy_sync,
    output logic              addr_latch,
    output logic              rd_n,
    output logic              wr_n,
    output logic [2:0]        bus_stat,
    output logic [ADDR_W-1:0] abus,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              cyc_done,
    output logic [DATA_W-1:0] rdata
);
    logic              rdy_eff;
    bus_st_e           state;
    cyc_e              kind_q;
    cyc_e              stat_e;
    logic [DATA_W-1:0] wdata_q;
    logic              supp_q;

    mbus_rdy #(.SYNC_STAGES(SYNC_STAGES)) u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdy_async (rdy_async),
        .rdy_sync  (rdy_sync),
        .rdy_eff   (rdy_eff)
    );

    mbus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (cyc_e'(req_kind)),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_supp   (req_cs_hit & req_da),
        .rdy        (rdy_eff),
        .ad_in      (ad_in),
        .req_ready  (req_ready),
        .state      (state),
        .kind_q     (kind_q),
        .addr_q     (abus),
        .wdata_q    (wdata_q),
        .supp_q     (supp_q),
        .addr_latch (addr_latch),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .bus_stat   (stat_e),
        .cyc_done   (cyc_done),
        .rdata      (rdata)
    );

    assign bus_stat = stat_e;

    mbus_addr_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap   (addr_dis_strap),
        .state   (state),
        .kind_q  (kind_q),
        .addr_q  (abus),
        .wdata_q (wdata_q),
        .supp_q  (supp_q),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe)
    );

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_latch,
    input logic              rd_n,
    input logic              wr_n,
    input logic [2:0]        bus_stat,
    input logic [ADDR_W-1:0] abus,
    input logic              ad_oe,
    input logic              rdy_async,
    input logic              rdy_sync,
    input logic              cyc_done
);
    a_r3_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch |=> !addr_latch);

    a_r12_no_strobe_in_t1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch |-> (rd_n && wr_n));

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r2_passive_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> (bus_stat == 3'b111));

    a_r3_abus_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> $stable(abus));

    a_r7_wait_holds_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_n || !wr_n) && !rdy_async && !rdy_sync) |=> (!rd_n || !wr_n));

    a_r6_write_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> ad_oe);

    a_r5_read_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && $past(!rd_n)) |-> !ad_oe);

endmodule

bind mbus_seq mbus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_latch (addr_latch),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .bus_stat   (bus_stat),
    .abus       (abus),
    .ad_oe      (ad_oe),
    .rdy_async  (rdy_async),
    .rdy_sync   (rdy_sync),
    .cyc_done   (cyc_done)
);

// File: tb/tb_mbus_seq.sv
`timescale 1ns/100ps
module tb_mbus_seq;

    typedef struct {
        logic [2:0]  kind;
        logic [19:0] addr;
        logic [7:0]  wd;
        bit          supp;
        int          waits;
        int          mode;   // 0 both ready high, 1 sync decides, 2 async decides
        bit          b2b;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_dis_strap = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'b000;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_cs_hit = 1'b0;
    logic        req_da = 1'b0;
    logic        rdy_async = 1'b1;
    logic        rdy_sync = 1'b1;
    logic        req_ready, addr_latch, rd_n, wr_n, ad_oe, cyc_done;
    logic [2:0]  bus_stat;
    logic [19:0] abus;
    logic [7:0]  ad_out, ad_in, rdata;

    int checks = 0;
    int errors = 0;
    bit strap_v = 1'b0;
    item_t q[$];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_fn(logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'hA5;
    endfunction

    assign ad_in = mem_fn(abus);

    mbus_seq dut (
        .clk(clk), .rst_n(rst_n), .addr_dis_strap(addr_dis_strap),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_cs_hit(req_cs_hit), .req_da(req_da),
        .req_ready(req_ready), .rdy_async(rdy_async), .rdy_sync(rdy_sync),
        .addr_latch(addr_latch), .rd_n(rd_n), .wr_n(wr_n), .bus_stat(bus_stat),
        .abus(abus), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .cyc_done(cyc_done), .rdata(rdata)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic bit is_rd(logic [2:0] k);
        return k == 3'b001 || k == 3'b100 || k == 3'b101;
    endfunction

    function automatic bit is_wr(logic [2:0] k);
        return k == 3'b010 || k == 3'b110;
    endfunction

    // monitor and ready responder
    int    cyc = 0, c = 0, rdcnt = 0, wrcnt = 0, last_done = -10;
    bit    active = 1'b0, wchk = 1'b0;
    item_t cur;

    initial begin
        forever begin
            @(posedge clk); #1;
            if (!rst_n) begin
                active = 1'b0;
                rdy_async = 1'b1;
                rdy_sync = 1'b1;
            end else begin
                cyc++;
                if (addr_latch) begin
                    if (q.size() == 0) check(1'b0, "R11 cycle without request", 1, 0);
                    else cur = q[0];
                    active = 1'b1; c = 0; rdcnt = 0; wrcnt = 0; wchk = 1'b0;
                    check(bus_stat == cur.kind, "R2 status code in T1", bus_stat, cur.kind);
                    check(abus == cur.addr, "R3 abus at T1", abus, cur.addr);
                    if (cur.b2b) check(cyc == last_done + 1, "R11 back-to-back gap", cyc - last_done, 1);
                end else if (active) begin
                    c++;
                    if (c <= 2 + cur.waits && c >= 1)
                        check(bus_stat == cur.kind, "R2 status held in T2/T3/Tw", bus_stat, cur.kind);
                end
                if (active) begin
                    case (cur.mode)
                        1: begin rdy_async = 1'b0; rdy_sync = (c >= 2 + cur.waits); end
                        2: begin rdy_sync = 1'b0; rdy_async = (c >= cur.waits); end
                        default: begin rdy_async = 1'b1; rdy_sync = 1'b1; end
                    endcase
                end else begin
                    rdy_async = 1'b1;
                    rdy_sync = 1'b1;
                end
                if (!rd_n) rdcnt++;
                if (!wr_n) wrcnt++;
                if (cyc_done) begin
                    last_done = cyc;
                    if (active) begin
                        check(bus_stat == 3'b111, "R2 passive in T4", bus_stat, 7);
                        check(c == 3 + cur.waits, "R7 R8 T4 position", c, 3 + cur.waits);
                        check(rdcnt == (is_rd(cur.kind) ? 2 + cur.waits : 0),
                              "R5 R12 read strobe cycles", rdcnt, is_rd(cur.kind) ? 2 + cur.waits : 0);
                        check(wrcnt == (is_wr(cur.kind) ? 2 + cur.waits : 0),
                              "R6 R12 write strobe cycles", wrcnt, is_wr(cur.kind) ? 2 + cur.waits : 0);
                        if (is_rd(cur.kind) || cur.kind == 3'b000)
                            check(rdata == mem_fn(cur.addr), "R10 captured data", rdata, mem_fn(cur.addr));
                        void'(q.pop_front());
                        active = 1'b0;
                    end
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n && active) begin
                if (c == 0) begin
                    check(ad_oe == !cur.supp, "R9 address phase drive", ad_oe, !cur.supp);
                    if (!cur.supp)
                        check(ad_out == cur.addr[7:0], "R4 AD address byte", ad_out, cur.addr[7:0]);
                end
                if (!rd_n) check(ad_oe == 1'b0, "R5 read releases AD", ad_oe, 0);
                if (!wr_n && !wchk) begin
                    wchk = 1'b1;
                    check(ad_oe && ad_out == cur.wd, "R6 write data on AD", ad_out, cur.wd);
                end
            end
        end
    end

    task automatic do_reset(input bit strap);
        rst_n = 1'b0;
        addr_dis_strap = strap;
        strap_v = strap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        addr_dis_strap = ~strap;
    endtask

    task automatic issue(input logic [2:0] k, input logic [19:0] a, input logic [7:0] wd,
                         input bit cs, input bit da, input int w, input int m, input bit b2b);
        item_t it;
        it.kind = k; it.addr = a; it.wd = wd; it.supp = strap_v & cs & da;
        it.waits = w; it.mode = m; it.b2b = b2b;
        @(negedge clk);
        req_kind = k; req_addr = a; req_wdata = wd; req_cs_hit = cs; req_da = da;
        req_valid = 1'b1;
        q.push_back(it);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #0.5;
        req_valid = 1'b0;
    endtask

    task automatic run(input logic [2:0] k, input logic [19:0] a, input logic [7:0] wd,
                       input bit cs, input bit da, input int w, input int m);
        issue(k, a, wd, cs, da, w, m, 1'b0);
        while (q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        @(posedge clk); #1;
        check(rd_n && wr_n, "R1 strobes idle after reset", {rd_n, wr_n}, 3);
        check(!addr_latch, "R1 latch low after reset", addr_latch, 0);
        check(bus_stat == 3'b111, "R1 R2 passive after reset", bus_stat, 7);
        check(!ad_oe, "R1 AD released after reset", ad_oe, 0);
        check(req_ready, "R1 R11 ready in idle", req_ready, 1);

        run(3'b101, 20'h1_2345, 8'h00, 1'b0, 1'b0, 0, 0);
        run(3'b110, 20'hA_0F0C, 8'h3C, 1'b1, 1'b1, 0, 0);   // R9: strap off, still driven
        run(3'b001, 20'h0_0080, 8'h00, 1'b0, 1'b0, 2, 1);
        run(3'b010, 20'h0_0042, 8'h99, 1'b0, 1'b0, 1, 1);
        run(3'b100, 20'hF_FFF0, 8'h00, 1'b0, 1'b0, 2, 2);   // R8 async rise
        run(3'b000, 20'h0_0000, 8'h00, 1'b0, 1'b0, 0, 0);
        run(3'b011, 20'h0_0002, 8'h00, 1'b0, 1'b0, 0, 0);
        run(3'b101, 20'h5_5AA5, 8'h00, 1'b0, 1'b0, 3, 2);

        issue(3'b101, 20'h2_0010, 8'h00, 1'b0, 1'b0, 0, 0, 1'b0);
        issue(3'b110, 20'h2_0011, 8'h7E, 1'b0, 1'b0, 1, 1, 1'b1);
        issue(3'b001, 20'h0_0300, 8'h00, 1'b0, 1'b0, 0, 0, 1'b1);
        while (q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk); #1;
        check(bus_stat == 3'b111, "R2 passive in idle", bus_stat, 7);

        do_reset(1'b1);
        run(3'b101, 20'h0_1234, 8'h00, 1'b1, 1'b1, 0, 0);
        run(3'b110, 20'hE_0001, 8'h5A, 1'b1, 1'b0, 0, 0);
        run(3'b001, 20'h0_0077, 8'h00, 1'b0, 1'b1, 1, 2);
        run(3'b110, 20'hF_8000, 8'hC3, 1'b1, 1'b1, 1, 2);
        run(3'b100, 20'hF_8002, 8'h00, 1'b1, 1'b1, 2, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule